// File: doc/BRIEF.md
# Delayed Single-Shot Pulse Timer

This block is a down-counting timer that produces exactly one pulse per start. Software first loads the counter with a delay value and loads a reload register with a width value. The timer is then started, either by a write of the software enable bit or by a rising edge on an external enable pin. After the delay has run out, the output flip-flop changes level and stays there for the programmed width. It then changes back, and the timer halts.

Counting advances only on cycles where the count-clock enable is high, so a prescaler outside the block sets the time base. The delay lasts (counter value + 1) ticks and the pulse lasts (reload value + 1) ticks. At each of the two underflows the block raises a one-cycle interrupt request strobe and, in the same cycle, a DMA request strobe. Fixed rules decide which event wins when a start, a stop and a disable fall in the same clock period.

Top module: `delay_pulse_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter readback is 0, the output is low, both request strobes are low, and the timer is stopped.
- R2: While running, the counter drops by one on each cycle with `cntTick` high and holds on cycles with `cntTick` low; while stopped it holds regardless of `cntTick`.
- R3: At the first underflow, the readback is all ones in the cycle after the underflow edge. At the next tick it becomes reload value minus one.
- R4: With counter value C and reload value R (R at least 1) and a tick every cycle, the output rises C+1 cycles after the start edge and stays high for R+1 cycles.
- R5: At the second underflow the timer stops with the readback held at all ones, and it does not restart unless it is started again.
- R6: `irqReq` and `dmaReq` are each high for exactly one cycle after each of the two underflows, and the output changes level in exactly those cycles.
- R7: Writing 1 through `swEnWr`/`swEnVal` starts the timer when `swAllow` is high. A 0-to-1 edge on `extEnIn` starts it when `extAllow` is high. A masked source has no effect.
- R8: An external start edge in the same cycle as the second underflow is lost: the timer stops.
- R9: A software enable write in the same cycle as the second underflow wins: counting continues down from all ones.
- R10: An external start edge in the same cycle as a software disable write (`swEnVal`=0) leaves the timer stopped.
- R11: A software disable write stops counting at once, and the counter holds its value.
- R12: A `wrCnt` write loads `wrData` into the counter, and the readback shows it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cntTick | input | 1 | Count-clock enable, one tick per high cycle |
| wrCnt | input | 1 | Write strobe for the counter |
| wrRld | input | 1 | Write strobe for the reload register |
| wrData | input | 16 | Write data for counter or reload |
| swEnWr | input | 1 | Write strobe for the software enable bit |
| swEnVal | input | 1 | Enable bit value: 1 start, 0 disable |
| swAllow | input | 1 | Mask for the software enable source (1 = allowed) |
| extEnIn | input | 1 | External enable pin, rising edge starts |
| extAllow | input | 1 | Mask for the external enable source (1 = allowed) |
| cntValue | output | 16 | Counter readback |
| pulseOut | output | 1 | Output flip-flop level |
| irqReq | output | 1 | Interrupt request strobe |
| dmaReq | output | 1 | DMA request strobe |

## Verification
If the phase flag is wrong, it shows within one tick of the first underflow. The readback then decrements from all ones instead of jumping to reload minus one, or the timer halts with the output still high. If the reload-pending flag is wrong, the counter takes a width that is one tick off, and the edge position of `pulseOut` shows that error in the same cycle. If the run bit is resolved wrongly in a collision, the readback moves, or fails to move, on the very next tick, so the collision tests sample the counter in the cycle after the contested edge.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  // Strobes from the control to the counter datapath
  typedef struct packed {
    logic decEn;   // decrement on this edge
    logic loadEn;  // load reload-minus-one on this edge
  } dpCtl_t;
endpackage

// File: rtl/dpt_edge.sv
module dpt_edge (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseOut
);
  logic prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= pinIn;
  end

  assign riseOut = pinIn && !prevQ;
endmodule

// File: rtl/dpt_datapath.sv
module dpt_datapath
  import dpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             wrCnt,
  input  logic             wrRld,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic             cntZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rldQ;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    cntNext = cntQ;
    if (wrCnt)           cntNext = wrData;
    else if (ctl.loadEn) cntNext = rldQ - ONE;
    else if (ctl.decEn)  cntNext = cntQ - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      rldQ <= '0;
    end else begin
      cntQ <= cntNext;
      if (wrRld) rldQ <= wrData;
    end
  end

  assign cntZero = (cntQ == '0);

  // R12
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt |=> cntQ == $past(wrData));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrCnt && !ctl.decEn && !ctl.loadEn) |=> $stable(cntQ));
  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadEn && !wrCnt && !wrRld) |=> cntQ == $past(rldQ) - ONE);
endmodule

// File: rtl/dpt_ctrl.sv
module dpt_ctrl
  import dpt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cntTick,
  input  logic   cntZero,
  input  logic   swEnWr,
  input  logic   swEnVal,
  input  logic   swAllow,
  input  logic   extRise,
  input  logic   extAllow,
  output dpCtl_t ctl,
  output logic   pulseQ,
  output logic   reqQ
);
  logic running, inWidth, loadPend;
  logic tickRun, uf, uf1, uf2;
  logic swOn, swOff, extOn;
  logic runNext, widthNext, pendNext;

  assign tickRun = running && cntTick;
  assign uf      = tickRun && !loadPend && cntZero;
  assign uf1     = uf && !inWidth;
  assign uf2     = uf && inWidth;
  assign swOn    = swEnWr && swAllow && swEnVal;
  assign swOff   = swEnWr && swAllow && !swEnVal;
  assign extOn   = extRise && extAllow;

  // Collision priority: disable > software start > stop > external start
  always_comb begin
    if (swOff)      runNext = 1'b0;
    else if (swOn)  runNext = 1'b1;
    else if (uf2)   runNext = 1'b0;
    else if (extOn) runNext = 1'b1;
    else            runNext = running;

    if (swOff || uf2) widthNext = 1'b0;
    else if (uf1)     widthNext = 1'b1;
    else              widthNext = inWidth;

    if (swOff)        pendNext = 1'b0;
    else if (uf1)     pendNext = 1'b1;
    else if (tickRun) pendNext = 1'b0;
    else              pendNext = loadPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      inWidth  <= 1'b0;
      loadPend <= 1'b0;
      pulseQ   <= 1'b0;
      reqQ     <= 1'b0;
    end else begin
      running  <= runNext;
      inWidth  <= widthNext;
      loadPend <= pendNext;
      reqQ     <= uf;
      if (uf) pulseQ <= !pulseQ;
    end
  end

  assign ctl.decEn  = tickRun && !loadPend;
  assign ctl.loadEn = tickRun && loadPend;

  // R6
  toggle_has_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ != $past(pulseQ)) |-> reqQ);
  // R6
  req_has_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |-> (pulseQ != $past(pulseQ)));
  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uf2 && extOn && !swOn) |=> !running);
  // R9
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uf2 && swOn) |=> running);
  // R10
  disable_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swOff && extOn) |=> !running);
endmodule

// File: rtl/delay_pulse_timer.sv
module delay_pulse_timer
  import dpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             wrCnt,
  input  logic             wrRld,
  input  logic [CNT_W-1:0] wrData,
  input  logic             swEnWr,
  input  logic             swEnVal,
  input  logic             swAllow,
  input  logic             extEnIn,
  input  logic             extAllow,
  output logic [CNT_W-1:0] cntValue,
  output logic             pulseOut,
  output logic             irqReq,
  output logic             dmaReq
);
  dpCtl_t ctl;
  logic   cntZero, extRise, reqQ;

  dpt_edge u_edge (
    .clk(clk), .rstN(rstN), .pinIn(extEnIn), .riseOut(extRise)
  );

  dpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntZero(cntZero),
    .swEnWr(swEnWr), .swEnVal(swEnVal), .swAllow(swAllow),
    .extRise(extRise), .extAllow(extAllow),
    .ctl(ctl), .pulseQ(pulseOut), .reqQ(reqQ)
  );

  dpt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrCnt(wrCnt), .wrRld(wrRld),
    .wrData(wrData), .cntQ(cntValue), .cntZero(cntZero)
  );

  assign irqReq = reqQ;
  assign dmaReq = reqQ;
endmodule

// File: tb/delay_pulse_timer_tb.sv
module delay_pulse_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 1'b0, wrCnt = 1'b0, wrRld = 1'b0;
  logic [15:0] wrData = '0;
  logic swEnWr = 1'b0, swEnVal = 1'b0, swAllow = 1'b1;
  logic extEnIn = 1'b0, extAllow = 1'b1;
  logic [15:0] cntValue;
  logic pulseOut, irqReq, dmaReq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  delay_pulse_timer u_dut (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrCnt(wrCnt), .wrRld(wrRld),
    .wrData(wrData), .swEnWr(swEnWr), .swEnVal(swEnVal), .swAllow(swAllow),
    .extEnIn(extEnIn), .extAllow(extAllow), .cntValue(cntValue),
    .pulseOut(pulseOut), .irqReq(irqReq), .dmaReq(dmaReq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] r);
    wrCnt = 1; wrData = c; step(); wrCnt = 0;
    chk(cntValue == c, "R12 counter write", cntValue, c);
    wrRld = 1; wrData = r; step(); wrRld = 0;
  endtask

  task automatic swWrite(input logic v);
    swEnWr = 1; swEnVal = v; step(); swEnWr = 0;
  endtask

  task automatic testReset();
    chk(cntValue == 0, "R1 counter", cntValue, 0);
    chk(pulseOut == 0, "R1 output", pulseOut, 0);
    chk(irqReq == 0 && dmaReq == 0, "R1 strobes", {irqReq, dmaReq}, 0);
    cntTick = 1; step(); step();
    chk(cntValue == 0, "R1 stopped", cntValue, 0);
  endtask

  // mode 0 plain, 1 sw enable at second underflow, 2 ext start at second underflow
  task automatic runShot(input int c, input int r, input int mode, input bit useExt);
    int rise = -1, fall = -1, irqN = 0, dmaN = 0;
    logic prevP;
    load(16'(c), 16'(r));
    cntTick = 1;
    if (useExt) begin extEnIn = 1; step(); extEnIn = 0; end
    else swWrite(1'b1);
    chk(cntValue == 16'(c), "R7 start no tick yet", cntValue, c);
    prevP = pulseOut;
    for (int k = 1; k <= c + r + 6; k++) begin
      if (k == c + r + 2 && mode == 1) begin swEnWr = 1; swEnVal = 1; end
      if (k == c + r + 2 && mode == 2) extEnIn = 1;
      step();
      swEnWr = 0; extEnIn = 0;
      if (pulseOut && !prevP) rise = k;
      if (!pulseOut && prevP) fall = k;
      prevP = pulseOut;
      if (irqReq) irqN++;
      if (dmaReq) dmaN++;
      if (k == 1) chk(cntValue == 16'(c - 1), "R2 decrement", cntValue, c - 1);
      if (k == c + 1) chk(cntValue == 16'hFFFF, "R3 underflow readback", cntValue, 16'hFFFF);
      if (k == c + 2) chk(cntValue == 16'(r - 1), "R3 reload minus one", cntValue, r - 1);
      if (k == c + r + 3 && mode == 1)
        chk(cntValue == 16'hFFFE, "R9 sw enable wins", cntValue, 16'hFFFE);
    end
    chk(rise == c + 1, "R4 pulse start", rise, c + 1);
    chk(fall - rise == r + 1, "R4 pulse width", fall - rise, r + 1);
    chk(irqN == 2 && dmaN == 2, "R6 strobe count", irqN * 16 + dmaN, 34);
    if (mode == 0) chk(cntValue == 16'hFFFF, "R5 halted", cntValue, 16'hFFFF);
    if (mode == 2) chk(cntValue == 16'hFFFF, "R8 stop wins", cntValue, 16'hFFFF);
    if (mode == 1) begin
      swWrite(1'b0);
      begin
        logic [15:0] held = cntValue;
        step(); step();
        chk(cntValue == held, "R11 disable holds", cntValue, held);
      end
    end
  endtask

  task automatic testTickGate();
    load(16'd10, 16'd2);
    cntTick = 0;
    swWrite(1'b1);
    step(); step();
    chk(cntValue == 10, "R2 hold without tick", cntValue, 10);
    cntTick = 1; step();
    chk(cntValue == 9, "R2 tick resumes", cntValue, 9);
    swWrite(1'b0);
  endtask

  task automatic testMasks();
    load(16'd20, 16'd2);
    cntTick = 1;
    extAllow = 0; extEnIn = 1; step(); extEnIn = 0; step();
    chk(cntValue == 20, "R7 ext masked", cntValue, 20);
    swAllow = 0; swWrite(1'b1); step();
    chk(cntValue == 20, "R7 sw masked", cntValue, 20);
    swAllow = 1; extAllow = 1;
  endtask

  task automatic testDisableVsExt();
    load(16'd20, 16'd2);
    cntTick = 1;
    extEnIn = 1; swEnWr = 1; swEnVal = 0; step();
    extEnIn = 0; swEnWr = 0; step(); step();
    chk(cntValue == 20, "R10 disable wins", cntValue, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1;
    step();
    testReset();
    runShot(3, 2, 0, 1'b0);
    runShot(0, 1, 0, 1'b0);
    runShot(5, 4, 0, 1'b1);
    runShot(2, 3, 1, 1'b0);
    runShot(4, 1, 2, 1'b0);
    testTickGate();
    testMasks();
    testDisableVsExt();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule